// File: doc/BRIEF.md
# Per-Page Spare Row Remapping Table

This block keeps, for every page of a resistive memory, a small associative table that maps faulty word addresses onto that page's own pool of spare rows. Every access presents its page and word address on the lookup port. All entries of the selected page are compared at once. One cycle later the block reports a hit together with the physical spare row that replaces the faulty word.

The repair controller drives the allocate port when it finds a word it cannot correct. The block gives that word the lowest-numbered free spare of its page. If the word is already mapped, the block returns the spare it already holds. When a page has used every spare it raises that page's exhausted flag, and the controller moves to the next repair stage: it activates the in-place spares of the whole page. At that point the controller issues a clear for the page, which frees all of the page's entries in one cycle.

Top module: `spare_remap_table`

## Requirements
- R1: After reset, lk_hit, al_ack and al_refused are 0, lk_row is 0, and every bit of exhausted is 0.
- R2: A lookup of a mapped (page, word) raises lk_hit in the cycle after it is presented. In that same cycle lk_row equals page*SPARES + spare index.
- R3: A lookup of a word that has no entry in its own page gives lk_hit 0 and lk_row 0 one cycle later. This holds even if the same word is mapped in another page.
- R4: An accepted allocation of an unmapped word takes the lowest-numbered free spare of its page. One cycle later it reports al_ack 1 and al_refused 0, with that index on al_spare. al_ack and al_refused are never both 1.
- R5: Allocating a word that is already mapped in its page reports al_ack with the spare it already holds and consumes no spare.
- R6: exhausted[p] is 1 exactly when all SPARES entries of page p are in use. While it is 1, allocating an unmapped word of page p reports al_refused one cycle later and changes no entry.
- R7: A clear of page p frees all of its entries from the next cycle on. Lookups of p then miss and exhausted[p] drops. Other pages keep their entries.
- R8: A lookup issued in the same cycle as a clear of the same page misses.
- R9: An allocation issued in the same cycle as a clear of the same page is refused, and the page is empty afterwards.
- R10: A new mapping is seen by lookups from the cycle after the allocation is accepted. A lookup of that word in the same cycle as its allocation misses.
- R11: On an exhausted page, allocating a word that is already mapped still reports al_ack with its existing spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | PG_W | Page of the lookup |
| lk_word | input | WORD_AW | Word address of the lookup |
| al_req | input | 1 | Allocation request from the repair controller |
| al_page | input | PG_W | Page of the allocation |
| al_word | input | WORD_AW | Faulty word address to be mapped |
| clr_req | input | 1 | Clear all entries of one page |
| clr_page | input | PG_W | Page to clear |
| lk_hit | output | 1 | Registered lookup hit |
| lk_row | output | ROW_W | Physical spare row on a hit, 0 on a miss |
| al_ack | output | 1 | Allocation granted (new or existing entry) |
| al_refused | output | 1 | Allocation refused |
| al_spare | output | SP_W | Spare index granted to the allocation |
| exhausted | output | PAGES | Per-page flag: no free spare left |

## Verification
A clear can fall in the same cycle as a lookup or an allocation on the same page. An allocation can also fall in the same cycle as a lookup of the word it is mapping. Directed sequences force each of these pairs, and a pseudo-random phase on a small address space produces more of them together with exhaustion. Each outcome is judged against a behavioural model in the bench. That model applies the clear first, answers lookups from the state before the edge, and predicts hit, row, grant, refusal and the exhausted flags on every cycle.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;
  typedef enum logic [1:0] {
    AL_IDLE   = 2'd0,
    AL_REUSE  = 2'd1,
    AL_NEW    = 2'd2,
    AL_REFUSE = 2'd3
  } al_outcome_e;
endpackage

// File: rtl/remap_first_set.sv
module remap_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/remap_page_bank.sv
module remap_page_bank #(
  parameter int SPARES  = 8,
  parameter int WORD_AW = 8,
  parameter int SP_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] lk_word,
  output logic               lk_hit,
  output logic [SP_W-1:0]    lk_idx,
  input  logic [WORD_AW-1:0] al_word,
  output logic               al_hit,
  output logic [SP_W-1:0]    al_idx,
  output logic [SP_W-1:0]    free_idx,
  output logic               full,
  input  logic               wr_en,
  input  logic               clr
);
  logic [SPARES-1:0]              valid_q, valid_d;
  logic [SPARES-1:0][WORD_AW-1:0] tag_q, tag_d;
  logic [SPARES-1:0]              lk_match, al_match;
  logic                           any_free;

  for (genvar e = 0; e < SPARES; e++) begin : g_cmp
    assign lk_match[e] = valid_q[e] && (tag_q[e] == lk_word);
    assign al_match[e] = valid_q[e] && (tag_q[e] == al_word);
  end

  remap_first_set #(.N(SPARES), .IW(SP_W)) u_lk_enc (
    .vec(lk_match), .idx(lk_idx), .any(lk_hit));
  remap_first_set #(.N(SPARES), .IW(SP_W)) u_al_enc (
    .vec(al_match), .idx(al_idx), .any(al_hit));
  remap_first_set #(.N(SPARES), .IW(SP_W)) u_free_enc (
    .vec(~valid_q), .idx(free_idx), .any(any_free));

  assign full = !any_free;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (clr) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[free_idx] = 1'b1;
      tag_d[free_idx]   = al_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (clr || wr_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  AST_UNIQUE_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!lk_hit && !full)); // R7
endmodule

// File: rtl/spare_remap_table.sv
module spare_remap_table
  import spare_remap_pkg::*;
#(
  parameter int PAGES   = 4,
  parameter int SPARES  = 8,
  parameter int WORD_AW = 8,
  localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int SP_W   = (SPARES > 1) ? $clog2(SPARES) : 1,
  localparam int ROW_W  = (PAGES * SPARES > 1) ? $clog2(PAGES * SPARES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [PG_W-1:0]    lk_page,
  input  logic [WORD_AW-1:0] lk_word,
  input  logic               al_req,
  input  logic [PG_W-1:0]    al_page,
  input  logic [WORD_AW-1:0] al_word,
  input  logic               clr_req,
  input  logic [PG_W-1:0]    clr_page,
  output logic               lk_hit,
  output logic [ROW_W-1:0]   lk_row,
  output logic               al_ack,
  output logic               al_refused,
  output logic [SP_W-1:0]    al_spare,
  output logic [PAGES-1:0]   exhausted
);
  logic [PAGES-1:0]           b_lk_hit, b_al_hit, b_full, b_wr, b_clr;
  logic [PAGES-1:0][SP_W-1:0] b_lk_idx, b_al_idx, b_free_idx;

  al_outcome_e     al_out;
  logic            lk_hit_d;
  logic [ROW_W-1:0] lk_row_d;
  logic [SP_W-1:0] al_spare_d;
  logic            lk_hit_q, al_ack_q, al_ref_q;
  logic [ROW_W-1:0] lk_row_q;
  logic [SP_W-1:0] al_spare_q;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign b_clr[p] = clr_req && (clr_page == PG_W'(p));
    assign b_wr[p]  = (al_out == AL_NEW) && (al_page == PG_W'(p));
    remap_page_bank #(.SPARES(SPARES), .WORD_AW(WORD_AW), .SP_W(SP_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lk_word(lk_word), .lk_hit(b_lk_hit[p]), .lk_idx(b_lk_idx[p]),
      .al_word(al_word), .al_hit(b_al_hit[p]), .al_idx(b_al_idx[p]),
      .free_idx(b_free_idx[p]), .full(b_full[p]),
      .wr_en(b_wr[p]), .clr(b_clr[p]));
  end

  always_comb begin
    lk_hit_d = lk_valid && b_lk_hit[lk_page]
               && !(clr_req && (clr_page == lk_page));
    lk_row_d = '0;
    if (lk_hit_d) begin
      lk_row_d = ROW_W'(lk_page) * ROW_W'(SPARES) + ROW_W'(b_lk_idx[lk_page]);
    end
  end

  always_comb begin
    al_out     = AL_IDLE;
    al_spare_d = al_spare_q;
    if (al_req) begin
      if (clr_req && (clr_page == al_page)) begin
        al_out = AL_REFUSE;
      end else if (b_al_hit[al_page]) begin
        al_out     = AL_REUSE;
        al_spare_d = b_al_idx[al_page];
      end else if (b_full[al_page]) begin
        al_out = AL_REFUSE;
      end else begin
        al_out     = AL_NEW;
        al_spare_d = b_free_idx[al_page];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit_q   <= 1'b0;
      lk_row_q   <= '0;
      al_ack_q   <= 1'b0;
      al_ref_q   <= 1'b0;
      al_spare_q <= '0;
    end else begin
      lk_hit_q <= lk_hit_d;
      lk_row_q <= lk_row_d;
      al_ack_q <= (al_out == AL_REUSE) || (al_out == AL_NEW);
      al_ref_q <= (al_out == AL_REFUSE);
      if (al_req) begin
        al_spare_q <= al_spare_d;
      end
    end
  end

  assign lk_hit     = lk_hit_q;
  assign lk_row     = lk_row_q;
  assign al_ack     = al_ack_q;
  assign al_refused = al_ref_q;
  assign al_spare   = al_spare_q;
  assign exhausted  = b_full;

  AST_ACK_REFUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(al_ack && al_refused)); // R4
  AST_RESPONSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (al_ack || al_refused) |-> $past(al_req)); // R4
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid)); // R2
  AST_CLEAR_BEATS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && lk_valid && (clr_page == lk_page)) |=> !lk_hit); // R8
  AST_CLEAR_BEATS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && al_req && (clr_page == al_page)) |=> al_refused); // R9
endmodule

// File: tb/tb_spare_remap_table.sv
`timescale 1ns/1ps
module tb_spare_remap_table;
  localparam int P  = 4;
  localparam int S  = 8;
  localparam int AW = 8;
  localparam int PG_W  = 2;
  localparam int SP_W  = 3;
  localparam int ROW_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, al_req, clr_req;
  logic [PG_W-1:0] lk_page, al_page, clr_page;
  logic [AW-1:0]   lk_word, al_word;
  logic lk_hit, al_ack, al_refused;
  logic [ROW_W-1:0] lk_row;
  logic [SP_W-1:0]  al_spare;
  logic [P-1:0]     exhausted;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string miss_tag = "R3";

  bit ref_v [P][S];
  int ref_t [P][S];

  always #2.5 clk = ~clk;

  spare_remap_table #(.PAGES(P), .SPARES(S), .WORD_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_page(lk_page), .lk_word(lk_word),
    .al_req(al_req), .al_page(al_page), .al_word(al_word),
    .clr_req(clr_req), .clr_page(clr_page),
    .lk_hit(lk_hit), .lk_row(lk_row), .al_ack(al_ack),
    .al_refused(al_refused), .al_spare(al_spare), .exhausted(exhausted));

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find(int p, int w);
    for (int s = 0; s < S; s++) if (ref_v[p][s] && ref_t[p][s] == w) return s;
    return -1;
  endfunction

  function automatic int first_free(int p);
    for (int s = 0; s < S; s++) if (!ref_v[p][s]) return s;
    return -1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One clock: inputs applied now (after a falling edge), results sampled at the next falling edge.
  task automatic cyc(bit lv, int lp, int lw, bit ar, int ap, int aw, bit cr, int cp);
    int e_hit, e_row, e_ack, e_ref, e_sp, idx, fr;
    string ltag, atag;
    lk_valid = lv; lk_page = PG_W'(lp); lk_word = AW'(lw);
    al_req = ar;   al_page = PG_W'(ap); al_word = AW'(aw);
    clr_req = cr;  clr_page = PG_W'(cp);
    e_hit = 0; e_row = 0; e_ack = 0; e_ref = 0; e_sp = -1;
    ltag = miss_tag; atag = "R4";
    if (lv) begin
      idx = find(lp, lw);
      if (cr && cp == lp) ltag = "R8";
      else if (idx >= 0) begin e_hit = 1; e_row = lp * S + idx; ltag = "R2"; end
      else if (ar && ap == lp && aw == lw) ltag = "R10";
    end
    if (ar) begin
      idx = find(ap, aw);
      fr  = first_free(ap);
      if (cr && cp == ap) begin e_ref = 1; atag = "R9"; end
      else if (idx >= 0) begin e_ack = 1; e_sp = idx; atag = (fr < 0) ? "R11" : "R5"; end
      else if (fr < 0) begin e_ref = 1; atag = "R6"; end
      else begin e_ack = 1; e_sp = fr; ref_v[ap][fr] = 1; ref_t[ap][fr] = aw; end
    end
    if (cr) for (int s = 0; s < S; s++) ref_v[cp][s] = 0;
    @(posedge clk);
    @(negedge clk);
    check(ltag, int'(lk_hit), e_hit, "lk_hit");
    check(ltag, int'(lk_row), e_row, "lk_row");
    check(atag, int'(al_ack), e_ack, "al_ack");
    check(atag, int'(al_refused), e_ref, "al_refused");
    if (e_sp >= 0) check(atag, int'(al_spare), e_sp, "al_spare");
    for (int p = 0; p < P; p++)
      check(cr ? "R7" : "R6", int'(exhausted[p]), (first_free(p) < 0) ? 1 : 0, "exhausted");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lfsr;
    for (int p = 0; p < P; p++) for (int s = 0; s < S; s++) begin ref_v[p][s] = 0; ref_t[p][s] = 0; end
    rst_n = 0; lk_valid = 0; al_req = 0; clr_req = 0;
    lk_page = '0; al_page = '0; clr_page = '0; lk_word = '0; al_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(lk_hit), 0, "lk_hit");
    check("R1", int'(al_ack), 0, "al_ack");
    check("R1", int'(al_refused), 0, "al_refused");
    check("R1", int'(exhausted), 0, "exhausted");
    check("R1", int'(lk_row), 0, "lk_row");
    rst_n = 1;
    @(negedge clk);
    // R4 lowest free, R10 same-cycle lookup misses
    cyc(1, 0, 8'h21, 1, 0, 8'h21, 0, 0);
    cyc(1, 0, 8'h21, 1, 0, 8'h35, 0, 0);   // R2 hit on spare 0
    cyc(1, 1, 8'h21, 1, 1, 8'h21, 0, 0);   // R3 other page misses
    cyc(1, 0, 8'h35, 1, 0, 8'h21, 0, 0);   // R5 reuse
    cyc(1, 0, 8'h99, 0, 0, 0, 0, 0);       // R3 unmapped
    // fill page 0 to exhaustion (R6)
    for (int i = 0; i < S; i++) cyc(1, 0, 8'h21, 1, 0, 8'h40 + i, 0, 0);
    cyc(1, 0, 8'h45, 1, 0, 8'h77, 0, 0);   // R6 refused
    cyc(1, 0, 8'h77, 1, 0, 8'h35, 0, 0);   // R11 reuse on full page, refused word stays unmapped
    // R8 clear with lookup, page 1 kept
    cyc(1, 0, 8'h21, 0, 0, 0, 1, 0);
    miss_tag = "R7";
    cyc(1, 0, 8'h35, 0, 0, 0, 0, 0);
    cyc(1, 1, 8'h21, 1, 0, 8'h55, 0, 0);   // page 1 kept, page 0 restarts at 0
    miss_tag = "R3";
    // R9 clear with allocate
    cyc(0, 0, 0, 1, 1, 8'h66, 1, 1);
    cyc(1, 1, 8'h66, 1, 1, 8'h67, 0, 0);
    cyc(1, 1, 8'h67, 1, 2, 8'h67, 1, 0);
    // pseudo-random phase
    lfsr = 32'h1ACE5;
    for (int n = 0; n < 600; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      cyc(lfsr[0], lfsr[2:1], lfsr[7:4], lfsr[8] | lfsr[9], lfsr[11:10], lfsr[15:12],
          (lfsr[20:16] == 0), lfsr[22:21]);
    end
    lk_valid = 0; al_req = 0; clr_req = 0;
    finish_run();
  end
endmodule